// File: doc/BRIEF.md
# Gate-list Boolean circuit evaluator

The block holds a Boolean circuit as a numbered list of gate records and evaluates it for an input vector of `N_VARS` bits. Before a run, software or a host engine writes records through the load port. Each record has a slot index, a type code and two child indices. A record either takes the two-input AND or OR of two earlier records, or it picks one of the `2*N_VARS` input literals, which are each variable and its complement. Inversion exists only at the literal level. There is no inverter gate.

A start pulse captures the input vector and the list length. The block then works through the list in increasing index order, one record per clock. It stores each record's value so that later records can use it. The value of the last record is the circuit's output. It is returned on `result_o` together with a one-cycle `done_o` pulse. Evaluation stops early and raises `error_o` in three cases: a gate names a child that is not strictly earlier in the list, a type code lies outside the defined range, or the requested length is zero or too large.

Top module: `netlist_eval`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `result_o` and `error_o` are all 0.
- R2: A record with type code 1 takes the AND of the stored values of its two child records.
- R3: A record with type code 2 takes the OR of the stored values of its two child records.
- R4: Type code `3+2*(i-1)` yields input bit `x_i[i-1]` and type code `4+2*(i-1)` yields its complement, for i from 1 to `N_VARS`.
- R5: The child fields of a literal record are ignored. Any value in them, even one at or beyond the record's own index, neither raises an error nor changes the result.
- R6: When no error occurs, `result_o` equals the value of record `len-1`, where len is the length captured at start.
- R7: A run of length L starts on the clock edge that samples `start_i`. `busy_o` then stays high for exactly L cycles. `done_o` is high for exactly one cycle, and that cycle begins L edges after the start edge.
- R8: A gate record (type 1 or 2) at index k with a child index greater than or equal to k stops the run. `done_o` then rises k+1 edges after the start edge, with `error_o`=1 and `result_o`=0.
- R9: A type code of 0, or one above `2*N_VARS+2`, stops the run in the same way and with the same timing as R8.
- R10: While `busy_o` is high, `start_i` and the load port have no effect. The stored records and the run in progress are unchanged.
- R11: A start with length 0 or greater than `MAX_GATES` runs no records. `done_o` and `error_o` are then high in the cycle right after the start edge.
- R12: `result_o` and `error_o` hold their values while idle until the next start, and an accepted start clears `error_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_en_i | input | 1 | Write one record this cycle |
| load_idx_i | input | IDX_W | Slot index of the record written |
| load_type_i | input | TYPE_W | Type code: 1 AND, 2 OR, 3..2N+2 literal |
| load_c1_i | input | IDX_W | First child index |
| load_c2_i | input | IDX_W | Second child index |
| len_i | input | IDX_W+1 | Number of records to evaluate, sampled at start |
| x_i | input | N_VARS | Input vector, sampled at start |
| start_i | input | 1 | Begin a run when idle |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse when a run ends |
| result_o | output | 1 | Circuit output of the last run |
| error_o | output | 1 | Last run stopped on an invalid record or length |

## Verification
The state that is hardest to reach from the ports is a circuit that is long and deeply nested, so that the last record depends on values stored many cycles earlier through both AND and OR paths. Reaching it also requires a start and a load to arrive in the middle of that run. Random lists with up to `MAX_GATES` records give gates children drawn only from earlier slots. Each list is run under several input vectors and checked against a bench model of the list. One full-length run is then disturbed by writes and start pulses while busy, and repeated afterwards to show that nothing was taken in.

// File: rtl/netlist_eval_pkg.sv
package netlist_eval_pkg;
  typedef enum logic {
    ST_IDLE,
    ST_RUN
  } state_e;

  typedef enum logic [1:0] {
    K_AND,
    K_OR,
    K_LIT,
    K_BAD
  } kind_e;
endpackage

// File: rtl/gate_store.sv
module gate_store #(
  parameter int MAX_GATES = 16,
  parameter int IDX_W     = 4,
  parameter int TYPE_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TYPE_W-1:0] wr_type_i,
  input  logic [IDX_W-1:0]  wr_c1_i,
  input  logic [IDX_W-1:0]  wr_c2_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [TYPE_W-1:0] rd_type_o,
  output logic [IDX_W-1:0]  rd_c1_o,
  output logic [IDX_W-1:0]  rd_c2_o
);
  logic [TYPE_W-1:0] type_q [MAX_GATES];
  logic [IDX_W-1:0]  c1_q   [MAX_GATES];
  logic [IDX_W-1:0]  c2_q   [MAX_GATES];

  for (genvar g = 0; g < MAX_GATES; g++) begin : g_slot
    logic hit;
    assign hit = we_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        type_q[g] <= '0;
        c1_q[g]   <= '0;
        c2_q[g]   <= '0;
      end else if (hit) begin
        type_q[g] <= wr_type_i;
        c1_q[g]   <= wr_c1_i;
        c2_q[g]   <= wr_c2_i;
      end
    end
  end

  // Combinational read: the record is usable in the cycle it is addressed.
  always_comb begin
    rd_type_o = '0;
    rd_c1_o   = '0;
    rd_c2_o   = '0;
    for (int g = 0; g < MAX_GATES; g++) begin
      if (rd_idx_i == IDX_W'(g)) begin
        rd_type_o = type_q[g];
        rd_c1_o   = c1_q[g];
        rd_c2_o   = c2_q[g];
      end
    end
  end
endmodule

// File: rtl/gate_alu.sv
module gate_alu
  import netlist_eval_pkg::*;
#(
  parameter int N_VARS = 4,
  parameter int IDX_W  = 4,
  parameter int TYPE_W = 4
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [IDX_W-1:0]  c1_i,
  input  logic [IDX_W-1:0]  c2_i,
  input  logic              c1_val_i,
  input  logic              c2_val_i,
  input  logic [N_VARS-1:0] x_i,
  output logic              val_o,
  output logic              err_o
);
  localparam int MAX_TYPE = 2 * N_VARS + 2;

  kind_e             kind;
  logic [TYPE_W-1:0] lit_off;
  logic              lit_bit;
  logic              child_bad;

  always_comb begin
    if (type_i == TYPE_W'(1))                                   kind = K_AND;
    else if (type_i == TYPE_W'(2))                              kind = K_OR;
    else if (type_i >= TYPE_W'(3) && type_i <= TYPE_W'(MAX_TYPE)) kind = K_LIT;
    else                                                        kind = K_BAD;
  end

  // Literal offset: bit 0 selects complement, upper bits select variable.
  assign lit_off = type_i - TYPE_W'(3);

  always_comb begin
    lit_bit = 1'b0;
    for (int i = 0; i < N_VARS; i++) begin
      if (lit_off[TYPE_W-1:1] == (TYPE_W-1)'(i)) lit_bit = x_i[i];
    end
  end

  assign child_bad = (c1_i >= idx_i) || (c2_i >= idx_i);

  always_comb begin
    val_o = 1'b0;
    err_o = 1'b0;
    unique case (kind)
      K_AND: begin
        val_o = c1_val_i & c2_val_i;
        err_o = child_bad;
      end
      K_OR: begin
        val_o = c1_val_i | c2_val_i;
        err_o = child_bad;
      end
      K_LIT:   val_o = lit_bit ^ lit_off[0];
      default: err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/eval_ctrl.sv
module eval_ctrl
  import netlist_eval_pkg::*;
#(
  parameter int N_VARS    = 4,
  parameter int MAX_GATES = 16,
  parameter int IDX_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IDX_W:0]    len_i,
  input  logic [N_VARS-1:0] x_i,
  input  logic [IDX_W-1:0]  c1_i,
  input  logic [IDX_W-1:0]  c2_i,
  input  logic              gate_val_i,
  input  logic              gate_err_i,
  output logic [IDX_W-1:0]  ptr_o,
  output logic [N_VARS-1:0] x_o,
  output logic              c1_val_o,
  output logic              c2_val_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              result_o,
  output logic              error_o
);
  localparam int LEN_W = IDX_W + 1;

  state_e               state_q;
  logic [IDX_W-1:0]     ptr_q;
  logic [LEN_W-1:0]     len_q;
  logic [N_VARS-1:0]    x_q;
  logic [MAX_GATES-1:0] val_q;
  logic                 done_q, result_q, error_q;
  logic                 len_ok, last;

  assign len_ok = (len_i != '0) && (len_i <= LEN_W'(MAX_GATES));
  assign last   = ({1'b0, ptr_q} == len_q - LEN_W'(1));

  always_comb begin
    c1_val_o = 1'b0;
    c2_val_o = 1'b0;
    for (int g = 0; g < MAX_GATES; g++) begin
      if (c1_i == IDX_W'(g)) c1_val_o = val_q[g];
      if (c2_i == IDX_W'(g)) c2_val_o = val_q[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ptr_q    <= '0;
      len_q    <= '0;
      x_q      <= '0;
      val_q    <= '0;
      done_q   <= 1'b0;
      result_q <= 1'b0;
      error_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            result_q <= 1'b0;
            ptr_q    <= '0;
            len_q    <= len_i;
            x_q      <= x_i;
            if (len_ok) begin
              error_q <= 1'b0;
              state_q <= ST_RUN;
            end else begin
              error_q <= 1'b1;
              done_q  <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (gate_err_i) begin
            error_q <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            for (int g = 0; g < MAX_GATES; g++) begin
              if (ptr_q == IDX_W'(g)) val_q[g] <= gate_val_i;
            end
            if (last) begin
              result_q <= gate_val_i;
              done_q   <= 1'b1;
              state_q  <= ST_IDLE;
            end else begin
              ptr_q <= ptr_q + IDX_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ptr_o    = ptr_q;
  assign x_o      = x_q;
  assign busy_o   = (state_q == ST_RUN);
  assign done_o   = done_q;
  assign result_o = result_q;
  assign error_o  = error_q;
endmodule

// File: rtl/netlist_eval.sv
module netlist_eval #(
  parameter int N_VARS    = 4,
  parameter int MAX_GATES = 16,
  parameter int IDX_W     = (MAX_GATES > 1) ? $clog2(MAX_GATES) : 1,
  parameter int TYPE_W    = $clog2(2 * N_VARS + 3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic [IDX_W-1:0]  load_idx_i,
  input  logic [TYPE_W-1:0] load_type_i,
  input  logic [IDX_W-1:0]  load_c1_i,
  input  logic [IDX_W-1:0]  load_c2_i,
  input  logic [IDX_W:0]    len_i,
  input  logic [N_VARS-1:0] x_i,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              result_o,
  output logic              error_o
);
  logic [IDX_W-1:0]  ptr;
  logic [TYPE_W-1:0] rec_type;
  logic [IDX_W-1:0]  rec_c1, rec_c2;
  logic [N_VARS-1:0] x_cur;
  logic              c1_val, c2_val, gate_val, gate_err;

  gate_store #(
    .MAX_GATES(MAX_GATES), .IDX_W(IDX_W), .TYPE_W(TYPE_W)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (load_en_i && !busy_o),
    .wr_idx_i  (load_idx_i),
    .wr_type_i (load_type_i),
    .wr_c1_i   (load_c1_i),
    .wr_c2_i   (load_c2_i),
    .rd_idx_i  (ptr),
    .rd_type_o (rec_type),
    .rd_c1_o   (rec_c1),
    .rd_c2_o   (rec_c2)
  );

  gate_alu #(
    .N_VARS(N_VARS), .IDX_W(IDX_W), .TYPE_W(TYPE_W)
  ) u_alu (
    .idx_i    (ptr),
    .type_i   (rec_type),
    .c1_i     (rec_c1),
    .c2_i     (rec_c2),
    .c1_val_i (c1_val),
    .c2_val_i (c2_val),
    .x_i      (x_cur),
    .val_o    (gate_val),
    .err_o    (gate_err)
  );

  eval_ctrl #(
    .N_VARS(N_VARS), .MAX_GATES(MAX_GATES), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .len_i      (len_i),
    .x_i        (x_i),
    .c1_i       (rec_c1),
    .c2_i       (rec_c2),
    .gate_val_i (gate_val),
    .gate_err_i (gate_err),
    .ptr_o      (ptr),
    .x_o        (x_cur),
    .c1_val_o   (c1_val),
    .c2_val_o   (c2_val),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o),
    .error_o    (error_o)
  );
endmodule

// File: rtl/netlist_eval_chk.sv
module netlist_eval_chk #(
  parameter int MAX_GATES = 16,
  parameter int IDX_W     = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [IDX_W:0] len_i,
  input logic           start_i,
  input logic           busy_o,
  input logic           done_o,
  input logic           result_o,
  input logic           error_o
);
  logic len_ok;
  assign len_ok = (len_i != '0) && (len_i <= (IDX_W+1)'(MAX_GATES));

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r7_start_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && len_ok) |=> busy_o);

  a_r10_busy_ends_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));

  a_r11_bad_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !len_ok) |=> (done_o && error_o && !busy_o));

  a_r12_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(result_o) && $stable(error_o)));

  a_r8_err_result_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !result_o);
endmodule

bind netlist_eval netlist_eval_chk #(
  .MAX_GATES(MAX_GATES), .IDX_W(IDX_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .len_i    (len_i),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o),
  .error_o  (error_o)
);

// File: tb/sim_netlist_eval.sv
`timescale 1ns/1ps
module sim_netlist_eval;
  localparam int NV   = 4;
  localparam int MG   = 16;
  localparam int IW   = 4;
  localparam int TW   = 4;
  localparam int MAXT = 2 * NV + 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_en_i = 1'b0;
  logic [IW-1:0] load_idx_i = '0;
  logic [TW-1:0] load_type_i = '0;
  logic [IW-1:0] load_c1_i = '0;
  logic [IW-1:0] load_c2_i = '0;
  logic [IW:0]   len_i = '0;
  logic [NV-1:0] x_i = '0;
  logic          start_i = 1'b0;
  logic          busy_o, done_o, result_o, error_o;

  int n_chk = 0;
  int n_fail = 0;
  int b_type [MG];
  int b_c1   [MG];
  int b_c2   [MG];

  always #2.5 clk_i = ~clk_i;

  netlist_eval #(.N_VARS(NV), .MAX_GATES(MG)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic put(input int idx, input int t, input int c1, input int c2);
    @(negedge clk_i);
    load_en_i = 1'b1; load_idx_i = IW'(idx); load_type_i = TW'(t);
    load_c1_i = IW'(c1); load_c2_i = IW'(c2);
    b_type[idx] = t; b_c1[idx] = c1; b_c2[idx] = c2;
    @(negedge clk_i);
    load_en_i = 1'b0;
  endtask

  // Reference: result, error flag, and negedge count to done after start edge.
  task automatic model(input int len, input logic [NV-1:0] x,
                       output int res, output int err, output int cyc);
    int v [MG];
    res = 0; err = 0; cyc = len + 1;
    if (len == 0 || len > MG) begin err = 1; cyc = 1; return; end
    for (int k = 0; k < len; k++) begin
      int t = b_type[k];
      if (t == 1 || t == 2) begin
        if (b_c1[k] >= k || b_c2[k] >= k) begin err = 1; cyc = k + 2; res = 0; return; end
        v[k] = (t == 1) ? (v[b_c1[k]] & v[b_c2[k]]) : (v[b_c1[k]] | v[b_c2[k]]);
      end else if (t >= 3 && t <= MAXT) begin
        v[k] = int'(x[(t - 3) / 2]) ^ ((t - 3) % 2);
      end else begin
        err = 1; cyc = k + 2; res = 0; return;
      end
    end
    res = v[len - 1];
  endtask

  task automatic run(input int len, input logic [NV-1:0] x, input string rq,
                     input bit disturb);
    int er, ee, ec, cnt;
    model(len, x, er, ee, ec);
    @(negedge clk_i);
    len_i = (IW+1)'(len); x_i = x; start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    if (disturb) begin
      // R10: writes and start while busy must be ignored
      load_en_i = 1'b1; load_idx_i = '0; load_type_i = TW'(1);
      load_c1_i = IW'(7); load_c2_i = IW'(9);
      start_i = 1'b1; x_i = ~x; len_i = 5'd2;
    end
    cnt = 1;
    while (!done_o && cnt < 60) begin
      @(negedge clk_i);
      if (disturb && cnt == 3) begin load_en_i = 1'b0; start_i = 1'b0; end
      cnt++;
    end
    load_en_i = 1'b0; start_i = 1'b0;
    chk(cnt == ec, {rq, " R7 done timing"}, cnt, ec);
    chk(int'(error_o) == ee, {rq, " error_o"}, int'(error_o), ee);
    chk(int'(result_o) == er, {rq, " R6 result"}, int'(result_o), er);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R7 done single pulse", int'(done_o), 0);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && done_o == 0, "R1 busy/done reset", int'({busy_o, done_o}), 0);
    chk(result_o == 0 && error_o == 0, "R1 result/error reset", int'({result_o, error_o}), 0);
    rst_ni = 1'b1;

    // R2 / R3: x1 AND x2, x1 OR x2 under all combinations
    put(0, 3, 0, 0); put(1, 5, 0, 0); put(2, 1, 0, 1);
    for (int p = 0; p < 4; p++) run(3, NV'(p), "R2 and", 1'b0);
    put(2, 2, 1, 0);
    for (int p = 0; p < 4; p++) run(3, NV'(p), "R3 or", 1'b0);

    // R4: every literal type on single-record lists
    for (int t = 3; t <= MAXT; t++) begin
      put(0, t, 0, 0);
      run(1, NV'($urandom), "R4 literal", 1'b0);
      run(1, NV'($urandom), "R4 literal", 1'b0);
    end

    // R5: literal with child fields at/above own index
    put(0, 4, 15, 15); put(1, 9, 1, 14); put(2, 2, 0, 1);
    run(3, 4'b0101, "R5 literal children ignored", 1'b0);
    run(3, 4'b1010, "R5 literal children ignored", 1'b0);

    // R8: child index equal to / above own index
    put(2, 1, 0, 2);
    run(3, 4'b1111, "R8 self child", 1'b0);
    put(2, 2, 3, 0);
    run(3, 4'b1111, "R8 forward child", 1'b0);
    put(0, 1, 0, 0);
    run(1, 4'b1111, "R8 gate at index 0", 1'b0);

    // R9: out-of-range types
    put(0, 3, 0, 0); put(1, 0, 0, 0);
    run(2, 4'b0001, "R9 type 0", 1'b0);
    put(1, MAXT + 1, 0, 0);
    run(2, 4'b0001, "R9 type above range", 1'b0);
    put(1, 15, 0, 0);
    run(2, 4'b0001, "R9 type 15", 1'b0);

    // R11: bad lengths; R12: next good start clears error
    run(0, 4'b0000, "R11 len 0", 1'b0);
    run(MG + 1, 4'b0000, "R11 len over max", 1'b0);
    put(1, 6, 0, 0);
    run(2, 4'b0010, "R12 error cleared", 1'b0);

    // R6 / R7: random topological lists, full length included
    for (int c = 0; c < 30; c++) begin
      int len = (c == 0) ? MG : 1 + int'($urandom % MG);
      for (int k = 0; k < len; k++) begin
        if (k == 0 || ($urandom % 3) == 0)
          put(k, 3 + int'($urandom % (2 * NV)), int'($urandom % MG), int'($urandom % MG));
        else
          put(k, 1 + int'($urandom % 2), int'($urandom % k), int'($urandom % k));
      end
      for (int r = 0; r < 3; r++) run(len, NV'($urandom), "R6 random", 1'b0);
      if (c == 0) begin
        // R10: disturb a full-length run, then repeat it undisturbed
        run(len, 4'b0110, "R10 busy disturb", 1'b1);
        run(len, 4'b1001, "R10 records kept", 1'b0);
        run(len, 4'b0110, "R10 records kept", 1'b0);
      end
    end

    // R12: idle hold with changing inputs
    begin
      logic hr, he;
      hr = result_o; he = error_o;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk_i);
        x_i = NV'($urandom); len_i = (IW+1)'($urandom);
      end
      chk(result_o == hr, "R12 result held", int'(result_o), int'(hr));
      chk(error_o == he, "R12 error held", int'(error_o), int'(he));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule